// File: doc/BRIEF.md
# Programmed-I/O Strobe Sequencer

This block turns one CPU access of 8, 16 or 32 bits into the strobe waveforms of a narrow external bus that is 8 or 16 bits wide. One word of per-channel timing configuration sets the read and write pulse lengths, the bus width and the address stepping, and selects which of four optional phases apply: pre-strobe, hold, float and recovery. The cycle counts of those four phases come from a shared common-delay word, so every channel that enables a phase gets the same length for it.

An access starts with a one-cycle request while the block is idle. Chip select then stays low for every bus beat the access needs. In each beat the block places the address and, for writes, the data. It then pulses the read or write strobe and leaves a gap after it. A read beat can be stretched by the external wait input. When chip select returns high, a one-cycle done pulse presents the assembled read word. All timing counts in cycles of the block's clock.

Top module: `pioStrobeSeq`

## Requirements
- R1: The write strobe stays low for cfgWord[3:0]+1 cycles and the read strobe for cfgWord[7:4]+1 cycles. Only the strobe that matches the access direction ever goes low, and only while chip select is low.
- R2: reqSize encodes 0 = byte, 1 = halfword, 2 or 3 = word. With cfgWord[12]=0 (8-bit bus) an access takes 1, 2 or 4 beats. With cfgWord[12]=1 (16-bit bus) a word takes 2 beats and the other sizes take 1. All beats fall inside one chip-select assertion whose length is the sum of the pulse, pre-strobe and gap cycles.
- R3: With cfgWord[13]=1, beat k drives address reqAddr + k on an 8-bit bus and reqAddr + 2k on a 16-bit bus. With cfgWord[13]=0, every beat drives reqAddr.
- R4: With cfgWord[11]=1 and P = commonDelay[15:12], each strobe falls P cycles after its beat starts, and its low time becomes max(base − P, 1), where base is the R1 length. Write data is already driven before the fall.
- R5: After every strobe pulse, including the last one before chip select rises, there is a gap. It is 1 cycle, plus commonDelay[3:0] when cfgWord[8]=1 (recovery).
- R6: With cfgWord[9]=1, write gaps grow by commonDelay[7:4] (hold). Read gaps are not affected.
- R7: With cfgWord[10]=1, read gaps grow by commonDelay[11:8] (float). Write gaps are not affected.
- R8: The read-time output is low for the whole chip-select assertion of a read and stays high throughout writes.
- R9: Upper byte enable goes low at the start of an access on a 16-bit channel and high on an 8-bit channel. It keeps that value after the access ends, until the next access starts.
- R10: With cfgWord[31]=1, a read strobe that reaches its configured end while waitN is low stays low until waitN is high. Writes, and reads with cfgWord[31]=0, ignore waitN.
- R11: Read data is captured on the last low cycle of each read strobe. Beat k fills byte k of doneRdata from busRdata[7:0] (8-bit bus) or halfword k from busRdata[15:0] (16-bit bus). Parts of the word that no beat fills read as zero.
- R12: doneValid is high for exactly one cycle: the first cycle in which chip select is high again.
- R13: During a write, busDataOe is high for the whole chip-select assertion. Beat k drives byte k of reqWdata on busWdata[7:0] with the upper byte zero (8-bit bus), or halfword k (16-bit bus). busDataOe stays low for reads.
- R14: In reset, chip select, both strobes, read-time and upper byte enable are high, and busDataOe, busy and doneValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start pulse for one access, taken while idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| reqAddr | input | ADDR_W | Base address of the access |
| reqWdata | input | 32 | Write word, little-endian |
| cfgWord | input | 32 | Channel timing/configuration word |
| commonDelay | input | 16 | Shared phase lengths: recovery, hold, float, pre-strobe |
| waitN | input | 1 | External wait, active low |
| busRdata | input | 16 | Data from the bus |
| busCsN | output | 1 | Chip select, active low |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busRtN | output | 1 | Read-time direction signal, active low |
| busUbeN | output | 1 | Upper byte enable, active low, latched |
| busAddr | output | ADDR_W | Bus address for the current beat |
| busWdata | output | 16 | Write data for the current beat |
| busDataOe | output | 1 | Write data drive enable |
| busy | output | 1 | Access in progress |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 32 | Assembled read word |

## Verification
The case that needs the most care is a wait release that falls in the same cycle as the strobe's configured last low cycle. In that cycle the stall condition and the end-of-pulse condition are both live. The bench sets a read pulse of known length L and releases waitN after W observed low cycles, with W before, equal to and after L. The first pulse must last exactly max(L, W) cycles and later pulses must stay at L. The same release pattern is applied to writes and to reads with waiting disabled; in both cases the pulse must keep its configured length. Gap lengths are checked against the arithmetic sum of all enabled phases for every combination of the four enable bits, in both directions.

// File: rtl/pioSeq_pkg.sv
package pioSeq_pkg;
  localparam int DLY_W  = 4;
  localparam int LEN_W  = DLY_W + 1;
  localparam int GAP_W  = DLY_W + 2;
  localparam int CNT_W  = GAP_W;
  localparam int BEAT_W = 2;
  localparam int BUS_W  = 16;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  localparam int F_WRLEN   = 0;
  localparam int F_RDLEN   = 4;
  localparam int F_RECEN   = 8;
  localparam int F_HOLDEN  = 9;
  localparam int F_FLOATEN = 10;
  localparam int F_PREEN   = 11;
  localparam int F_WIDE    = 12;
  localparam int F_AINC    = 13;
  localparam int F_WAITEN  = 31;

  localparam int C_REC   = 0;
  localparam int C_HOLD  = 4;
  localparam int C_FLOAT = 8;
  localparam int C_PRE   = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_GAP} seqState_t;

  typedef struct packed {
    logic              start;
    logic              csActive;
    logic              strobeOn;
    logic              capture;
    logic              writeOp;
    logic [BEAT_W-1:0] beat;
  } seqCtl_t;

  function automatic logic [BEAT_W-1:0] lastBeatOf(input logic [1:0] size, input logic wide);
    if (wide) return (size[1]) ? BEAT_W'(1) : BEAT_W'(0);
    case (size)
      2'd0:    return BEAT_W'(0);
      2'd1:    return BEAT_W'(1);
      default: return BEAT_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/pioSeqCtrl.sv
module pioSeqCtrl
  import pioSeq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic [31:0] cfgWord,
  input  logic [15:0] commonDelay,
  input  logic        waitN,
  output logic        busCsN,
  output logic        busRdN,
  output logic        busWrN,
  output logic        busRtN,
  output logic        busy,
  output logic        doneValid,
  output seqCtl_t     ctl
);
  seqState_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [BEAT_W-1:0] beat, lastBeat;
  logic              isWrite, waitEn;
  logic [LEN_W-1:0]  strobeLen;
  logic [DLY_W-1:0]  preLen;
  logic [GAP_W-1:0]  gapLen;

  logic [LEN_W-1:0]  baseLenC, strobeLenC;
  logic [DLY_W-1:0]  preLenC;
  logic [GAP_W-1:0]  gapLenC;
  logic              start, stall, strobeEnd, strobeOn;
  logic              unusedCfgBits;

  assign unusedCfgBits = ^cfgWord[30:12];

  // Per-access lengths are worked out once, when the request is taken.
  always_comb begin
    baseLenC = LEN_W'(reqWrite ? cfgWord[F_WRLEN +: DLY_W] : cfgWord[F_RDLEN +: DLY_W]) + LEN_W'(1);
    preLenC  = cfgWord[F_PREEN] ? commonDelay[C_PRE +: DLY_W] : '0;
    strobeLenC = (baseLenC > LEN_W'(preLenC)) ? baseLenC - LEN_W'(preLenC) : LEN_W'(1);
    gapLenC = GAP_W'(1);
    if (cfgWord[F_RECEN])               gapLenC = gapLenC + GAP_W'(commonDelay[C_REC +: DLY_W]);
    if (cfgWord[F_HOLDEN] && reqWrite)  gapLenC = gapLenC + GAP_W'(commonDelay[C_HOLD +: DLY_W]);
    if (cfgWord[F_FLOATEN] && !reqWrite) gapLenC = gapLenC + GAP_W'(commonDelay[C_FLOAT +: DLY_W]);
  end

  assign start     = (state == ST_IDLE) && reqValid;
  assign stall     = !isWrite && waitEn && !waitN;
  assign strobeOn  = (state == ST_STROBE);
  assign strobeEnd = strobeOn && (cnt == '0) && !stall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      beat      <= '0;
      lastBeat  <= '0;
      isWrite   <= 1'b0;
      waitEn    <= 1'b0;
      strobeLen <= '0;
      preLen    <= '0;
      gapLen    <= '0;
      doneValid <= 1'b0;
    end else begin
      doneValid <= 1'b0;
      unique case (state)
        ST_IDLE: if (reqValid) begin
          isWrite   <= reqWrite;
          waitEn    <= cfgWord[F_WAITEN];
          strobeLen <= strobeLenC;
          preLen    <= preLenC;
          gapLen    <= gapLenC;
          lastBeat  <= lastBeatOf(reqSize, cfgWord[F_WIDE]);
          beat      <= '0;
          if (preLenC != '0) begin
            state <= ST_SETUP;
            cnt   <= CNT_W'(preLenC - DLY_W'(1));
          end else begin
            state <= ST_STROBE;
            cnt   <= CNT_W'(strobeLenC - LEN_W'(1));
          end
        end
        ST_SETUP: if (cnt == '0) begin
          state <= ST_STROBE;
          cnt   <= CNT_W'(strobeLen - LEN_W'(1));
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
        ST_STROBE: if (cnt != '0) begin
          cnt <= cnt - CNT_W'(1);
        end else if (!stall) begin
          state <= ST_GAP;
          cnt   <= CNT_W'(gapLen - GAP_W'(1));
        end
        ST_GAP: if (cnt != '0) begin
          cnt <= cnt - CNT_W'(1);
        end else if (beat == lastBeat) begin
          state     <= ST_IDLE;
          doneValid <= 1'b1;
        end else begin
          beat <= beat + BEAT_W'(1);
          if (preLen != '0) begin
            state <= ST_SETUP;
            cnt   <= CNT_W'(preLen - DLY_W'(1));
          end else begin
            state <= ST_STROBE;
            cnt   <= CNT_W'(strobeLen - LEN_W'(1));
          end
        end
      endcase
    end
  end

  assign busCsN = (state == ST_IDLE);
  assign busy   = !busCsN;
  assign busRdN = !(strobeOn && !isWrite);
  assign busWrN = !(strobeOn && isWrite);
  assign busRtN = !(!busCsN && !isWrite);

  always_comb begin
    ctl          = '0;
    ctl.start    = start;
    ctl.csActive = !busCsN;
    ctl.strobeOn = strobeOn;
    ctl.capture  = strobeEnd && !isWrite;
    ctl.writeOp  = isWrite;
    ctl.beat     = beat;
  end

  // R1: a strobe is only ever low inside chip select
  p_strobe_in_cs_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdN || !busWrN) |-> !busCsN);
  // R1: never both strobes at once
  p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(!busRdN && !busWrN));
  // R8: read-time stays high while writing
  p_rt_reads_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busWrN |-> busRtN);
  // R10: an enabled wait keeps a read strobe low
  p_wait_holds_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdN && waitEn && !waitN) |=> !busRdN);
  // R12: done is a single cycle and only with chip select released
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> busCsN);
endmodule

// File: rtl/pioSeqDatapath.sv
module pioSeqDatapath
  import pioSeq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [31:0]       cfgWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [BUS_W-1:0]  busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BUS_W-1:0]  busWdata,
  output logic              busDataOe,
  output logic              busUbeN,
  output logic [WORD_W-1:0] doneRdata
);
  logic              wide, ainc;
  logic [ADDR_W-1:0] baseAddr;
  logic [WORD_W-1:0] wdataReg, rdAcc;
  logic [BEAT_W:0]   step;
  logic              unusedCfgBits;

  assign unusedCfgBits = ^{cfgWord[31:14], cfgWord[11:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wide     <= 1'b0;
      ainc     <= 1'b0;
      baseAddr <= '0;
      wdataReg <= '0;
      rdAcc    <= '0;
      busUbeN  <= 1'b1;
    end else if (ctl.start) begin
      wide     <= cfgWord[F_WIDE];
      ainc     <= cfgWord[F_AINC];
      baseAddr <= reqAddr;
      wdataReg <= reqWdata;
      rdAcc    <= '0;
      busUbeN  <= !cfgWord[F_WIDE];
    end else if (ctl.capture) begin
      if (wide) rdAcc[{ctl.beat[0], 4'b0000} +: BUS_W] <= busRdata;
      else      rdAcc[{ctl.beat, 3'b000} +: BYTE_W]    <= busRdata[BYTE_W-1:0];
    end
  end

  always_comb begin
    if (!ainc)     step = '0;
    else if (wide) step = {ctl.beat, 1'b0};
    else           step = {1'b0, ctl.beat};
  end

  assign busAddr   = baseAddr + ADDR_W'(step);
  assign busWdata  = wide ? wdataReg[{ctl.beat[0], 4'b0000} +: BUS_W]
                          : {{(BUS_W-BYTE_W){1'b0}}, wdataReg[{ctl.beat, 3'b000} +: BYTE_W]};
  assign busDataOe = ctl.csActive && ctl.writeOp;
  assign doneRdata = rdAcc;

  // R3: the address holds steady across a strobe pulse
  p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.strobeOn && $past(ctl.strobeOn) && $past(ctl.beat) == ctl.beat) |-> $stable(busAddr));
  // R9: upper byte enable only moves when an access starts
  p_ube_latched_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.start |=> $stable(busUbeN));
  // R11: capture only happens for reads
  p_capture_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> !ctl.writeOp);
endmodule

// File: rtl/pioStrobeSeq.sv
module pioStrobeSeq
  import pioSeq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       cfgWord,
  input  logic [15:0]       commonDelay,
  input  logic              waitN,
  input  logic [15:0]       busRdata,
  output logic              busCsN,
  output logic              busRdN,
  output logic              busWrN,
  output logic              busRtN,
  output logic              busUbeN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [15:0]       busWdata,
  output logic              busDataOe,
  output logic              busy,
  output logic              doneValid,
  output logic [31:0]       doneRdata
);
  seqCtl_t ctl;

  pioSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .cfgWord(cfgWord), .commonDelay(commonDelay),
    .waitN(waitN), .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN),
    .busRtN(busRtN), .busy(busy), .doneValid(doneValid), .ctl(ctl)
  );

  pioSeqDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgWord(cfgWord),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata), .busDataOe(busDataOe),
    .busUbeN(busUbeN), .doneRdata(doneRdata)
  );
endmodule

// File: tb/pioStrobeSeq_tb.sv
module pioStrobeSeq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0, cfgWord = '0;
  logic [15:0] commonDelay = '0;
  logic        waitN = 1'b1;
  logic [15:0] busRdata;
  logic        busCsN, busRdN, busWrN, busRtN, busUbeN, busDataOe, busy, doneValid;
  logic [15:0] busAddr, busWdata;
  logic [31:0] doneRdata;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] devData(input logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a[7:0] ^ 8'h3C};
  endfunction
  assign busRdata = devData(busAddr);

  pioStrobeSeq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgWord(cfgWord), .commonDelay(commonDelay), .waitN(waitN),
    .busRdata(busRdata), .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN),
    .busRtN(busRtN), .busUbeN(busUbeN), .busAddr(busAddr), .busWdata(busWdata),
    .busDataOe(busDataOe), .busy(busy), .doneValid(doneValid), .doneRdata(doneRdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runAcc(input logic wr, input logic [1:0] sz, input logic [15:0] addr,
                        input logic [31:0] wd, input logic [31:0] cfg,
                        input logic [15:0] cd, input int waitLow);
    bit wide = cfg[12];
    bit ainc = cfg[13];
    int beats, baseLen, pre, sLen, gap, exp0, expCs;
    int pl[5], gp[5];
    int np = 0, csCnt = 0, highRun = 0, lowSeen = 0;
    bit inLow = 0, sawEnd = 0;
    int addrBad = 0, dataBad = 0, rtBad = 0, ubeBad = 0, oeBad = 0, otherBad = 0;
    logic [31:0] expRd = '0;
    logic [15:0] aK, expW;
    for (int i = 0; i < 5; i++) begin pl[i] = 0; gp[i] = 0; end
    if (wide) beats = sz[1] ? 2 : 1;
    else      beats = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    baseLen = (wr ? int'(cfg[3:0]) : int'(cfg[7:4])) + 1;
    pre  = cfg[11] ? int'(cd[15:12]) : 0;
    sLen = (baseLen > pre) ? baseLen - pre : 1;
    gap  = 1 + (cfg[8] ? int'(cd[3:0]) : 0) + ((cfg[9] && wr) ? int'(cd[7:4]) : 0)
             + ((cfg[10] && !wr) ? int'(cd[11:8]) : 0);
    exp0 = (!wr && cfg[31] && waitLow > 0 && waitLow > sLen) ? waitLow : sLen;
    expCs = exp0 + (beats - 1) * sLen + beats * (pre + gap);
    for (int k = 0; k < beats; k++) begin
      aK = addr + (ainc ? 16'(k * (wide ? 2 : 1)) : 16'd0);
      if (wide) expRd[16*k +: 16] = devData(aK);
      else      expRd[8*k +: 8]   = devData(aK)[7:0];
    end
    cfgWord = cfg; commonDelay = cd; reqWrite = wr; reqSize = sz;
    reqAddr = addr; reqWdata = wd; reqValid = 1'b1;
    waitN = (waitLow > 0) ? 1'b0 : 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      logic strobe, other;
      strobe = wr ? busWrN : busRdN;
      other  = wr ? busRdN : busWrN;
      if (busCsN) begin sawEnd = 1; break; end
      csCnt++;
      if (other !== 1'b1) otherBad++;
      if (busRtN !== (wr ? 1'b1 : 1'b0)) rtBad++;
      if (busUbeN !== !wide) ubeBad++;
      if (busDataOe !== wr) oeBad++;
      if (strobe === 1'b0) begin
        if (!inLow) begin
          inLow = 1;
          if (np < 5) gp[np] = highRun;
          aK = addr + (ainc ? 16'(np * (wide ? 2 : 1)) : 16'd0);
          if (busAddr !== aK) addrBad++;
          if (wr) begin
            expW = wide ? wd[16*(np%2) +: 16] : {8'h00, wd[8*(np%4) +: 8]};
            if (busWdata !== expW) dataBad++;
          end
        end
        if (np < 5) pl[np]++;
        lowSeen++;
        if (lowSeen == waitLow) waitN = 1'b1;
      end else begin
        if (inLow) begin inLow = 0; np++; highRun = 0; end
        highRun++;
      end
      @(negedge clk);
    end
    waitN = 1'b1;
    if (inLow) np++;
    chk(sawEnd && np == beats, "R2", "beat count", np, beats);
    chk(csCnt == expCs, "R2", "chip-select length", csCnt, expCs);
    chk(pl[0] == exp0, "R1 R4 R10", "first pulse length", pl[0], exp0);
    begin
      bit ok = 1;
      for (int k = 1; k < beats; k++) if (pl[k] != sLen || gp[k] != gap + pre) ok = 0;
      chk(ok, "R1 R5 R6 R7", "later pulses/gaps", beats > 1 ? pl[beats-1] * 256 + gp[beats-1] : 0,
          beats > 1 ? sLen * 256 + gap + pre : 0);
    end
    chk(gp[0] == pre, "R4", "pre-strobe offset", gp[0], pre);
    chk(highRun == gap, "R5", "tail gap before release", highRun, gap);
    chk(addrBad == 0, "R3", "beat addresses", addrBad, 0);
    chk(otherBad == 0, "R1", "wrong-direction strobe", otherBad, 0);
    chk(rtBad == 0, "R8", "read-time level", rtBad, 0);
    chk(oeBad == 0 && dataBad == 0, "R13", "write data/enable", oeBad + dataBad, 0);
    chk(ubeBad == 0, "R9", "upper byte enable during access", ubeBad, 0);
    chk(doneValid === 1'b1, "R12", "done in first released cycle", doneValid, 1);
    if (!wr) chk(doneRdata === expRd, "R11", "read word", doneRdata, expRd);
    @(negedge clk);
    chk(doneValid === 1'b0, "R12", "done single cycle", doneValid, 0);
    chk(busUbeN === !wide, "R9", "upper byte enable latched", busUbeN, !wide);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busCsN === 1 && busRdN === 1 && busWrN === 1 && busRtN === 1 && busUbeN === 1
        && busDataOe === 0 && busy === 0 && doneValid === 0, "R14", "reset outputs",
        {busCsN, busRdN, busWrN, busRtN, busUbeN, busDataOe, busy, doneValid}, 8'b11111000);
    rstN = 1'b1;
    @(negedge clk);

    // structure sweep: direction, width, size, address stepping
    for (int wr = 0; wr < 2; wr++)
      for (int wd = 0; wd < 2; wd++)
        for (int sz = 0; sz < 3; sz++)
          for (int ai = 0; ai < 2; ai++)
            runAcc(wr[0], sz[1:0], 16'h12F0 + 16'(sz * 7 + ai), 32'hA1B2C3D4 ^ 32'(sz),
                   {18'd0, ai[0], wd[0], 4'h0, 4'h1, 4'h2}, 16'h0000, 0);

    // pulse length sweep with pre-strobe shortening (R1 R4)
    for (int v = 0; v < 16; v++)
      for (int p = 0; p < 4; p++)
        for (int wr = 0; wr < 2; wr++) begin
          int pv = (p == 0) ? 0 : (p == 1) ? 2 : (p == 2) ? 7 : 15;
          runAcc(wr[0], 2'd2, 16'h0040, 32'h5566_7788, {18'd0, 1'b1, 1'b0, (p != 0), 3'b000,
                 v[3:0], v[3:0]}, {pv[3:0], 12'h000}, 0);
        end

    // every combination of the optional phase enables (R5 R6 R7)
    for (int opt = 0; opt < 16; opt++)
      for (int wr = 0; wr < 2; wr++)
        for (int wd = 0; wd < 2; wd++) begin
          runAcc(wr[0], 2'd2, 16'h0100, 32'h0F1E2D3C, {18'd0, 1'b1, wd[0], opt[3:0], 4'h3, 4'h2},
                 16'h1234, 0);
          runAcc(wr[0], 2'd2, 16'h0200, 32'hCAFEF00D, {18'd0, 1'b1, wd[0], opt[3:0], 4'h0, 4'h5},
                 16'hF0A7, 0);
        end

    // wait release before, at and after the nominal strobe end (R10)
    for (int w = 0; w < 10; w++) begin
      runAcc(1'b0, 2'd2, 16'h0300, 32'h0, {1'b1, 17'd0, 1'b1, 5'd0, 4'h3, 4'h0}, 16'h0000, w);
      runAcc(1'b0, 2'd1, 16'h0310, 32'h0, {1'b1, 17'd0, 1'b1, 1'b1, 4'h8, 4'h3, 4'h0}, 16'h2000, w);
      runAcc(1'b1, 2'd2, 16'h0320, 32'h89ABCDEF, {1'b1, 17'd0, 1'b1, 5'd0, 4'h0, 4'h3}, 16'h0000, w);
      runAcc(1'b0, 2'd2, 16'h0330, 32'h0, {1'b0, 17'd0, 1'b1, 5'd0, 4'h3, 4'h0}, 16'h0000, w);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule